// File: doc/BRIEF.md
# Pipelined Loop Kernel Engine

This block runs one fixed loop body in hardware, `y[i] = a * x[i] + b` (or `a * x[i] - b` when the `SUBTRACT` parameter is set). Integer arithmetic is used and the result is truncated to `DATA_W` bits. A new iteration is started every `II` cycles, and `II` is a parameter from 1 to 4. Because an iteration takes longer than `II` cycles, the operations of several iterations are in flight at the same time.

There are three function units: a load unit, a multiplier and an adder/subtracter. Each unit writes only into its own shift chain, and every entry of every chain moves one place down on every clock. A consumer picks its operand from the chain entry that matches how far it sits from its producer in time. The picking is done by a multiplexer whose select comes from a constant kernel table indexed by a modulo-`II` slot counter. That table also says which unit is active in each slot. A small central register file holds the loop constants `a` and `b`.

In use, software writes the constants and then pulses `startPulse` with a trip count. The block then issues one memory read per iteration. It streams out one result per iteration in order and raises `loopDone` after the last result.

Top module: `lacc_top`

## Requirements
- R1: Straight after reset, `memRdEn`, `resValid` and `loopDone` are low.
- R2: Writing `liveData` with `liveWe` high stores it in the live-in entry at `liveAddr`. Entry 0 is the multiplier coefficient `a` and entry 1 is the addend `b`. Each value is held across runs until that entry is rewritten, and writes to any other entry have no effect on results.
- R3: A start accepted at a clock edge makes `memRdEn` high in the following cycle, because the slot counter restarts at slot 0. Reads then occur every `II` cycles, exactly `iterCount` of them, with `memRdAddr` counting 0, 1, 2 and so on.
- R4: Result k on `resData` equals `a * x[k] + b`, truncated to `DATA_W` bits, where `x[k]` is the word returned for read k one cycle after that read. Results come out in iteration order.
- R5: Each result appears with `resValid` exactly `L2M + M2A + 2` cycles after the cycle of its read, which is 7 cycles with the default parameters.
- R6: Iterations overlap: the next read is issued before the previous result appears, and the results stay correct. Every operand select stays inside the shift chain depth.
- R7: `loopDone` rises in the cycle after the last result. It stays high, with no reads and no results, until the next accepted start, and it is low during a run.
- R8: A start with `iterCount` equal to 0 raises `loopDone` in the next cycle without any read or result.
- R9: A start pulse that arrives while a run is in progress is ignored. The run keeps its original trip count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Starts a run when the block is idle |
| iterCount | input | CNT_W | Trip count, sampled with the accepted start |
| liveWe | input | 1 | Live-in register write enable |
| liveAddr | input | LIVE_AW | Live-in register index (0 = a, 1 = b) |
| liveData | input | DATA_W | Live-in write data |
| memRdEn | output | 1 | Operand read request, one per iteration |
| memRdAddr | output | CNT_W | Iteration index of the read |
| memRdData | input | DATA_W | Read data, valid the cycle after the request |
| resValid | output | 1 | Result strobe |
| resData | output | DATA_W | Result of one iteration |
| loopDone | output | 1 | High once every result of the run has been emitted |

## Verification
Suppose the slot counter, or an iteration's position in a shift chain, goes wrong. A consumer then picks the entry that belongs to a neighbouring iteration. The result shows up at once, at the very first `resValid`, as a value built from the wrong `x`, or as a result that arrives at the wrong distance from its read. A fault in the trip or drain bookkeeping shows up instead at the end of the run. In that case `loopDone` comes early or late relative to the last result, or the read and result counts differ from `iterCount`. Running several trip counts, with and without constants rewritten between runs, covers both kinds of fault within a few tens of cycles.

// File: rtl/lacc_pkg.sv
package lacc_pkg;
  localparam int SEL_W = 4;  // chain depth up to 16 entries

  // one row of the kernel table: which units act in a slot and where they read
  typedef struct packed {
    logic             ldOn;
    logic             mulOn;
    logic             addOn;
    logic [SEL_W-1:0] mulSel;
    logic [SEL_W-1:0] addSel;
  } kernRow_t;

  // strobes from control to datapath
  typedef struct packed {
    logic             issue;
    logic             ldFire;
    logic             mulFire;
    logic             addFire;
    logic             outValid;
    logic [SEL_W-1:0] mulSel;
    logic [SEL_W-1:0] addSel;
  } laccStrobe_t;
endpackage

// File: rtl/lacc_srf.sv
module lacc_srf #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      wrEn,
  input  logic [W-1:0]              wrData,
  input  logic [lacc_pkg::SEL_W-1:0] rdSel,
  output logic [W-1:0]              rdData
);
  logic [W-1:0] chain [DEPTH];

  // every entry moves down each cycle; the head takes the unit result or zero
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < DEPTH; k++) chain[k] <= '0;
    end else begin
      chain[0] <= wrEn ? wrData : '0;
      for (int k = 1; k < DEPTH; k++) chain[k] <= chain[k-1];
    end
  end

  // point-to-point operand mux over all entries
  always_comb begin
    rdData = '0;
    for (int k = 0; k < DEPTH; k++)
      if (rdSel == lacc_pkg::SEL_W'(k)) rdData = chain[k];
  end
endmodule

// File: rtl/lacc_ctrl.sv
module lacc_ctrl
  import lacc_pkg::*;
#(
  parameter int II    = 2,
  parameter int L2M   = 2,
  parameter int M2A   = 3,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic [CNT_W-1:0] iterCount,
  output laccStrobe_t      strobes,
  output logic             memRdEn,
  output logic [CNT_W-1:0] memRdAddr,
  output logic             loopDone
);
  localparam int LD_OFS  = 1;               // memory returns one cycle after the read
  localparam int MUL_OFS = LD_OFS + L2M;
  localparam int ADD_OFS = MUL_OFS + M2A;
  localparam int OUT_OFS = ADD_OFS + 1;
  localparam int ST_W    = (II > 1) ? $clog2(II) : 1;

  logic [ST_W-1:0]    slot;
  logic               busy;
  logic               doneQ;
  logic [CNT_W-1:0]   remaining;
  logic [CNT_W-1:0]   iterIdx;
  logic [OUT_OFS:1]   hist;     // hist[k]: an iteration was issued k cycles ago
  kernRow_t           kernTab [II];
  kernRow_t           row;
  logic               issue;
  logic               lastOut;

  // constant kernel table derived from the schedule offsets
  always_comb begin
    for (int s = 0; s < II; s++) begin
      kernTab[s].ldOn   = ((LD_OFS % II) == s);
      kernTab[s].mulOn  = ((MUL_OFS % II) == s);
      kernTab[s].addOn  = ((ADD_OFS % II) == s);
      kernTab[s].mulSel = SEL_W'(L2M - 1);
      kernTab[s].addSel = SEL_W'(M2A - 1);
    end
  end

  assign row     = kernTab[slot];
  assign issue   = busy && (slot == '0) && (remaining != '0);
  assign lastOut = hist[OUT_OFS] && (hist[OUT_OFS-1:1] == '0) && (remaining == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slot      <= '0;
      busy      <= 1'b0;
      doneQ     <= 1'b0;
      remaining <= '0;
      iterIdx   <= '0;
      hist      <= '0;
    end else begin
      hist <= {hist[OUT_OFS-1:1], issue};
      if (startPulse && !busy) begin
        slot      <= '0;
        iterIdx   <= '0;
        remaining <= iterCount;
        busy      <= (iterCount != '0);
        doneQ     <= (iterCount == '0);
      end else if (busy) begin
        slot <= (slot == ST_W'(II - 1)) ? '0 : slot + 1'b1;
        if (issue) begin
          remaining <= remaining - 1'b1;
          iterIdx   <= iterIdx + 1'b1;
        end
        if (lastOut) begin
          busy  <= 1'b0;
          doneQ <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    strobes.issue    = issue;
    strobes.ldFire   = hist[LD_OFS]  && row.ldOn;
    strobes.mulFire  = hist[MUL_OFS] && row.mulOn;
    strobes.addFire  = hist[ADD_OFS] && row.addOn;
    strobes.outValid = hist[OUT_OFS];
    strobes.mulSel   = row.mulSel;
    strobes.addSel   = row.addSel;
  end

  assign memRdEn   = issue;
  assign memRdAddr = iterIdx;
  assign loopDone  = doneQ;
endmodule

// File: rtl/lacc_datapath.sv
module lacc_datapath
  import lacc_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int DEPTH    = 4,
  parameter int NUM_LIVE = 4,
  parameter bit SUBTRACT = 1'b0
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  laccStrobe_t                 strobes,
  input  logic                        liveWe,
  input  logic [$clog2(NUM_LIVE)-1:0] liveAddr,
  input  logic [DATA_W-1:0]           liveData,
  input  logic [DATA_W-1:0]           memRdData,
  output logic                        resValid,
  output logic [DATA_W-1:0]           resData
);
  logic [DATA_W-1:0] liveFile [NUM_LIVE];
  logic [DATA_W-1:0] ldOperand;
  logic [DATA_W-1:0] mulOperand;
  logic [DATA_W-1:0] mulResult;
  logic [DATA_W-1:0] addResult;
  logic [2*DATA_W-1:0] prodFull;

  // central live-in file: entry 0 = coefficient, entry 1 = addend
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < NUM_LIVE; k++) liveFile[k] <= '0;
    end else if (liveWe) begin
      liveFile[liveAddr] <= liveData;
    end
  end

  assign prodFull  = ldOperand * liveFile[0];
  assign mulResult = prodFull[DATA_W-1:0];

  generate
    if (SUBTRACT) begin : g_sub
      assign addResult = mulOperand - liveFile[1];
    end else begin : g_add
      assign addResult = mulOperand + liveFile[1];
    end
  endgenerate

  lacc_srf #(.W(DATA_W), .DEPTH(DEPTH)) u_srfLd (
    .clk(clk), .rstN(rstN), .wrEn(strobes.ldFire), .wrData(memRdData),
    .rdSel(strobes.mulSel), .rdData(ldOperand));

  lacc_srf #(.W(DATA_W), .DEPTH(DEPTH)) u_srfMul (
    .clk(clk), .rstN(rstN), .wrEn(strobes.mulFire), .wrData(mulResult),
    .rdSel(strobes.addSel), .rdData(mulOperand));

  lacc_srf #(.W(DATA_W), .DEPTH(DEPTH)) u_srfAdd (
    .clk(clk), .rstN(rstN), .wrEn(strobes.addFire), .wrData(addResult),
    .rdSel('0), .rdData(resData));

  assign resValid = strobes.outValid;
endmodule

// File: rtl/lacc_top.sv
module lacc_top
  import lacc_pkg::*;
#(
  parameter int II       = 2,
  parameter int L2M      = 2,
  parameter int M2A      = 3,
  parameter int DEPTH    = 4,
  parameter int DATA_W   = 16,
  parameter int CNT_W    = 8,
  parameter int NUM_LIVE = 4,
  parameter bit SUBTRACT = 1'b0,
  localparam int LIVE_AW = $clog2(NUM_LIVE)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startPulse,
  input  logic [CNT_W-1:0]   iterCount,
  input  logic               liveWe,
  input  logic [LIVE_AW-1:0] liveAddr,
  input  logic [DATA_W-1:0]  liveData,
  output logic               memRdEn,
  output logic [CNT_W-1:0]   memRdAddr,
  input  logic [DATA_W-1:0]  memRdData,
  output logic               resValid,
  output logic [DATA_W-1:0]  resData,
  output logic               loopDone
);
  laccStrobe_t strobes;

  lacc_ctrl #(.II(II), .L2M(L2M), .M2A(M2A), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .iterCount(iterCount),
    .strobes(strobes), .memRdEn(memRdEn), .memRdAddr(memRdAddr),
    .loopDone(loopDone));

  lacc_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH), .NUM_LIVE(NUM_LIVE),
                  .SUBTRACT(SUBTRACT)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .liveWe(liveWe),
    .liveAddr(liveAddr), .liveData(liveData), .memRdData(memRdData),
    .resValid(resValid), .resData(resData));
endmodule

// File: rtl/lacc_chk.sv
module lacc_chk
  import lacc_pkg::*;
#(
  parameter int II    = 2,
  parameter int DEPTH = 4
) (
  input logic        clk,
  input logic        rstN,
  input laccStrobe_t strobes,
  input logic        memRdEn,
  input logic        resValid,
  input logic        loopDone
);
  assert_mul_sel_depth_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.mulFire |-> (int'(strobes.mulSel) < DEPTH));

  assert_add_sel_depth_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.addFire |-> (int'(strobes.addSel) < DEPTH));

  assert_done_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    loopDone |-> (!memRdEn && !resValid));

  assert_result_follows_add_R5: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> $past(strobes.addFire));

  generate
    if (II > 1) begin : g_gap
      assert_read_gap_R3: assert property (@(posedge clk) disable iff (!rstN)
        memRdEn |=> !memRdEn);
      assert_result_gap_R6: assert property (@(posedge clk) disable iff (!rstN)
        resValid |=> !resValid);
    end
  endgenerate
endmodule

bind lacc_top lacc_chk #(.II(II), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .strobes(strobes), .memRdEn(memRdEn),
  .resValid(resValid), .loopDone(loopDone));

// File: tb/lacc_top_tb.sv
module lacc_top_tb;
  localparam int PERIOD = 10;
  localparam int II     = 2;
  localparam int LAT    = 7;   // R5: L2M + M2A + 2 with defaults

  typedef struct packed {
    logic [15:0] a;
    logic [15:0] b;
    logic [7:0]  n;
    logic        wr;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{a: 16'd3,     b: 16'd7,     n: 8'd5, wr: 1'b1},
    '{a: 16'hFFFF,  b: 16'd100,   n: 8'd8, wr: 1'b1},
    '{a: 16'd0,     b: 16'h1234,  n: 8'd3, wr: 1'b1},
    '{a: 16'd0,     b: 16'd0,     n: 8'd6, wr: 1'b0}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startPulse = 1'b0;
  logic [7:0]  iterCount = '0;
  logic        liveWe = 1'b0;
  logic [1:0]  liveAddr = '0;
  logic [15:0] liveData = '0;
  logic        memRdEn;
  logic [7:0]  memRdAddr;
  logic [15:0] memRdData;
  logic        resValid;
  logic [15:0] resData;
  logic        loopDone;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  logic [15:0] curA = '0;
  logic [15:0] curB = '0;

  lacc_top u_dut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .iterCount(iterCount),
    .liveWe(liveWe), .liveAddr(liveAddr), .liveData(liveData),
    .memRdEn(memRdEn), .memRdAddr(memRdAddr), .memRdData(memRdData),
    .resValid(resValid), .resData(resData), .loopDone(loopDone));

  always #(PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] memVal(input int i);
    return 16'(i * 613 + 91);
  endfunction

  // memory model: one cycle read latency
  always @(posedge clk) memRdData <= memVal(int'(memRdAddr));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic writeLive(input logic [1:0] addr, input logic [15:0] val);
    @(negedge clk);
    liveWe = 1'b1; liveAddr = addr; liveData = val;
    @(negedge clk);
    liveWe = 1'b0;
  endtask

  task automatic runLoop(input int n, input bit midStart);
    int reads = 0;
    int results = 0;
    int lastRead = 0;
    int lastRes = 0;
    int startCyc;
    int readCyc [256];
    bit finished = 0;
    logic [15:0] exp;
    @(negedge clk);
    startPulse = 1'b1; iterCount = 8'(n);
    @(negedge clk);
    startPulse = 1'b0;
    startCyc = cyc;
    check(loopDone == 1'b0, "R7 done low in run", int'(loopDone), 0);
    for (int t = 0; t < 400 && !finished; t++) begin
      if (t > 0) @(negedge clk);
      if (midStart && t == 3) begin startPulse = 1'b1; iterCount = 8'd2; end
      else startPulse = 1'b0;
      if (memRdEn) begin
        check(int'(memRdAddr) == reads, "R3 read address", int'(memRdAddr), reads);
        if (reads == 0) check(cyc == startCyc, "R3 first read cycle", cyc, startCyc);
        else check(cyc - lastRead == II, "R3 read spacing", cyc - lastRead, II);
        readCyc[reads] = cyc;
        lastRead = cyc;
        reads++;
      end
      if (resValid) begin
        exp = 16'(curA * memVal(results) + curB);
        check(resData == exp, "R4 R6 result value", int'(resData), int'(exp));
        if (results < reads)
          check(cyc - readCyc[results] == LAT, "R5 latency", cyc - readCyc[results], LAT);
        if (results == 0 && n >= 2)
          check(reads > 1, "R6 overlap", reads, 2);
        lastRes = cyc;
        results++;
      end
      if (loopDone) begin
        check(results == n, "R7 R9 result count", results, n);
        check(reads == n, "R3 R9 read count", reads, n);
        check(cyc == lastRes + 1, "R7 done timing", cyc, lastRes + 1);
        finished = 1;
      end
    end
    startPulse = 1'b0;
    check(finished, "R7 run completes", int'(finished), 1);
  endtask

  initial begin
    #(PERIOD * 50000);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=finish");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(memRdEn == 1'b0,  "R1 reset read", int'(memRdEn), 0);
    check(resValid == 1'b0, "R1 reset valid", int'(resValid), 0);
    check(loopDone == 1'b0, "R1 reset done", int'(loopDone), 0);

    foreach (VECS[i]) begin
      if (VECS[i].wr) begin
        writeLive(2'd0, VECS[i].a);
        writeLive(2'd1, VECS[i].b);
        curA = VECS[i].a;
        curB = VECS[i].b;
      end else begin
        writeLive(2'd2, 16'hBEEF);  // R2: unused entry must not change results
      end
      runLoop(int'(VECS[i].n), 1'b0);
    end

    // R7: done holds while idle
    repeat (3) @(negedge clk);
    check(loopDone == 1'b1, "R7 done holds", int'(loopDone), 1);
    check(memRdEn == 1'b0,  "R7 idle no read", int'(memRdEn), 0);

    // R9: start during a run is ignored
    writeLive(2'd0, 16'd5); writeLive(2'd1, 16'd2);
    curA = 16'd5; curB = 16'd2;
    runLoop(6, 1'b1);

    // R8: zero trip count
    @(negedge clk);
    startPulse = 1'b1; iterCount = 8'd0;
    @(negedge clk);
    startPulse = 1'b0;
    check(loopDone == 1'b1, "R8 done at once", int'(loopDone), 1);
    check(memRdEn == 1'b0,  "R8 no read", int'(memRdEn), 0);
    repeat (2) @(negedge clk);
    check(resValid == 1'b0, "R8 no result", int'(resValid), 0);
    check(memRdEn == 1'b0,  "R8 still no read", int'(memRdEn), 0);

    // R2: constants kept across a zero run, single iteration
    runLoop(1, 1'b0);

    summary();
    $finish;
  end
endmodule